// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block watches the calendar time produced by a clock core and raises an alarm when that time matches a programmed pattern. The pattern is held in six byte-wide alarm registers: second, minute, hour, weekday, day of month and month. Each holds a BCD value in bits 6:0 and a participate bit in bit 7. Any subset of the six fields can make up the pattern. A field whose participate bit is clear is left out of the comparison, so writing zero to a register removes its field. Years are never compared.

The comparison runs only in the cycle in which the clock core signals a seconds update (`sec_tick`). If at least one field participates and every participating field equals the current count, a sticky alarm flag is set. The flag stays set until software writes the control register with the flag bit at 0. The interrupt line is the flag gated by an interrupt-enable bit in the same control register. A small flag state machine holds the flag. Its state `FLAG_IDLE` means no alarm is pending and `FLAG_PENDING` means an alarm is latched. The transition `ARM_HIT` (a tick with a full match) moves it from idle to pending. The transition `SW_CLEAR` (a clearing control write with no simultaneous hit) moves it back to idle. All other cycles hold the state.

Register map (3-bit address): 0 second, 1 minute, 2 hour, 3 weekday, 4 day of month, 5 month (BCD 01 to 12), 6 control. Reads are combinational on `reg_addr`; writes take effect at the clock edge where `reg_wr` is high.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset all six alarm registers read 0x00, the control register reads 0x00 and `alarm_irq` is low.
- R2: A write to address 0 to 5 stores all eight data bits, and a read of that address returns them unchanged.
- R3: The control register (address 6) reads the alarm flag in bit 0 and the interrupt enable in bit 3, with all other bits reading 0. A write loads bit 3 into the enable.
- R4: On a clock edge where `sec_tick` is high, at least one field has bit 7 set, and every such field's bits 6:0 equal the matching time input (whose bit 7 is 0), the flag reads 1 from the next cycle on.
- R5: A field with bit 7 clear is ignored: a mismatch between its bits 6:0 and the time input does not prevent the flag from being set.
- R6: When no alarm register has bit 7 set, a tick never sets the flag, including when all time inputs and alarm values are zero.
- R7: Without `sec_tick` the flag is never set, even while the enabled fields match.
- R8: Once set, the flag stays set through later non-matching ticks and through control writes with bit 0 = 1. It is cleared only by a control write with bit 0 = 0.
- R9: When a clearing control write and a matching tick fall on the same edge, the flag ends up set.
- R10: `alarm_irq` is high exactly when both the flag and the interrupt enable are 1.
- R11: A single enabled field that differs from its time input (for example, month alarm 0x12 against month count 0x11) keeps the flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse marking a seconds update of the time inputs |
| now_sec | input | 8 | Current second, BCD |
| now_min | input | 8 | Current minute, BCD |
| now_hour | input | 8 | Current hour, BCD |
| now_wday | input | 8 | Current weekday, BCD |
| now_mday | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD 01 to 12 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The comparator is exercised with a single enabled field, with two enabled fields beside a disabled field that holds a conflicting non-zero value, with all six fields enabled at their upper BCD limits, and with every field disabled, including an all-zero alarm against an all-zero time. These patterns separate a design that ignores the participate bit from one that compares the wrong bits, and from one that treats "no field enabled" as a match. Stimulus where the fields match but no tick arrives shows that the tick gates the comparison. A one-field mismatch in the month shows that one differing field is enough to block the match. Clear-only writes, writes with bit 0 = 1 and a clear coinciding with a hit tell the sticky clear rule and its priority apart.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int ALM_FIELDS  = 6;
    localparam int ALM_DATA_W  = 8;
    localparam int ALM_ADDR_W  = 3;

    // Bit positions inside registers; software depends on them.
    localparam int PART_BIT    = 7;   // participate bit of an alarm field
    localparam int FLAG_BIT    = 0;   // alarm flag in control register
    localparam int IEN_BIT     = 3;   // interrupt enable in control register

    localparam logic [ALM_ADDR_W-1:0] CTRL_ADDR = 3'd6;

    typedef enum logic [2:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_WDAY = 3'd3,
        FLD_MDAY = 3'd4,
        FLD_MON  = 3'd5
    } field_e;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

endpackage

// File: rtl/alarm_field_bank.sv
module alarm_field_bank #(
    parameter int FIELDS = alarm_pkg::ALM_FIELDS,
    parameter int DW     = alarm_pkg::ALM_DATA_W,
    parameter int AW     = alarm_pkg::ALM_ADDR_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wdata,
    output logic [FIELDS-1:0][DW-1:0] field_q
);

    // One byte register per alarm field, each with its own address decode.
    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        logic sel;
        assign sel = wr && (addr == AW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                field_q[g] <= '0;
            end else if (sel) begin
                field_q[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
    parameter int DW       = alarm_pkg::ALM_DATA_W,
    parameter int PART_POS = alarm_pkg::PART_BIT
) (
    input  logic [DW-1:0] alarm_val,
    input  logic [DW-1:0] now_val,
    output logic          part,
    output logic          pass
);

    localparam int VAL_W = PART_POS;

    logic equal;

    always_comb begin
        part  = alarm_val[PART_POS];
        // The count's upper bit must be 0 and the BCD digits must agree.
        equal = (now_val == DW'(alarm_val[VAL_W-1:0]));
        // A field that does not participate never blocks a match.
        pass  = !part || equal;
    end

endmodule

// File: rtl/alarm_flag_fsm.sv
module alarm_flag_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic clear_req,
    input  logic ien_wr,
    input  logic ien_val,
    output logic flag,
    output logic ien,
    output logic irq
);

    import alarm_pkg::*;

    flag_state_e state_q, state_d;
    logic        ien_q;
    logic        arm_hit;

    assign arm_hit = tick && hit;

    // Next-state logic: a hit on the tick always wins over a clear.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (arm_hit) state_d = FLAG_PENDING;     // ARM_HIT
            end
            FLAG_PENDING: begin
                if (clear_req && !arm_hit) state_d = FLAG_IDLE; // SW_CLEAR
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Interrupt-enable bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else if (ien_wr) begin
            ien_q <= ien_val;
        end
    end

    // Outputs.
    always_comb begin
        flag = 1'b0;
        unique case (state_q)
            FLAG_IDLE:    flag = 1'b0;
            FLAG_PENDING: flag = 1'b1;
            default:      flag = 1'b0;
        endcase
        ien = ien_q;
        irq = flag && ien_q;
    end

endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
    parameter int FIELDS = alarm_pkg::ALM_FIELDS,
    parameter int DW     = alarm_pkg::ALM_DATA_W,
    parameter int AW     = alarm_pkg::ALM_ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic [7:0]    now_sec,
    input  logic [7:0]    now_min,
    input  logic [7:0]    now_hour,
    input  logic [7:0]    now_wday,
    input  logic [7:0]    now_mday,
    input  logic [7:0]    now_mon,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          alarm_irq
);

    import alarm_pkg::*;

    logic [FIELDS-1:0][DW-1:0] field_q;
    logic [FIELDS-1:0][DW-1:0] now_vec;
    logic [FIELDS-1:0]         field_en;
    logic [FIELDS-1:0]         field_pass;
    logic                      match_hit;
    logic                      ctrl_wr;
    logic                      clear_req;
    logic                      flag_q;
    logic                      irq_en_q;

    always_comb begin
        now_vec          = '0;
        now_vec[FLD_SEC]  = now_sec;
        now_vec[FLD_MIN]  = now_min;
        now_vec[FLD_HOUR] = now_hour;
        now_vec[FLD_WDAY] = now_wday;
        now_vec[FLD_MDAY] = now_mday;
        now_vec[FLD_MON]  = now_mon;
    end

    alarm_field_bank #(.FIELDS(FIELDS), .DW(DW), .AW(AW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .field_q (field_q)
    );

    for (genvar g = 0; g < FIELDS; g++) begin : g_cmp
        alarm_field_cmp #(.DW(DW), .PART_POS(PART_BIT)) u_cmp (
            .alarm_val (field_q[g]),
            .now_val   (now_vec[g]),
            .part      (field_en[g]),
            .pass      (field_pass[g])
        );
    end

    // Full match: at least one participant, and no participant disagrees.
    assign match_hit = (|field_en) && (&field_pass);

    assign ctrl_wr   = reg_wr && (reg_addr == CTRL_ADDR);
    assign clear_req = ctrl_wr && !reg_wdata[FLAG_BIT];

    alarm_flag_fsm u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sec_tick),
        .hit       (match_hit),
        .clear_req (clear_req),
        .ien_wr    (ctrl_wr),
        .ien_val   (reg_wdata[IEN_BIT]),
        .flag      (flag_q),
        .ien       (irq_en_q),
        .irq       (alarm_irq)
    );

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < FIELDS; i++) begin
            if (reg_addr == AW'(i)) reg_rdata = field_q[i];
        end
        if (reg_addr == CTRL_ADDR) begin
            reg_rdata[FLAG_BIT] = flag_q;
            reg_rdata[IEN_BIT]  = irq_en_q;
        end
    end

endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk #(
    parameter int FIELDS = alarm_pkg::ALM_FIELDS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              hit,
    input logic              clear_req,
    input logic [FIELDS-1:0] en_mask,
    input logic              flag,
    input logic              ien,
    input logic              irq
);

    assert_hit_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit) |=> flag);

    assert_hit_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit && clear_req) |=> flag);

    assert_no_set_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !flag) |=> !flag);

    assert_empty_mask_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (en_mask == '0) && !flag) |=> !flag);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clear_req) |=> flag);

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && ien));

endmodule

bind alarm_match_unit alarm_match_chk #(.FIELDS(FIELDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sec_tick),
    .hit       (match_hit),
    .clear_req (clear_req),
    .en_mask   (field_en),
    .flag      (flag_q),
    .ien       (irq_en_q),
    .irq       (alarm_irq)
);

// File: tb/tb_alarm_match_unit.sv
module tb_alarm_match_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [7:0] t_now [6];
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       alarm_irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;   // 100 MHz

    alarm_match_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .now_sec   (t_now[0]),
        .now_min   (t_now[1]),
        .now_hour  (t_now[2]),
        .now_wday  (t_now[3]),
        .now_mday  (t_now[4]),
        .now_mon   (t_now[5]),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .alarm_irq (alarm_irq)
    );

    // Behavioural reference model.
    logic [7:0] m_alm [6];
    logic       m_flag;
    logic       m_ien;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) m_alm[i] = 8'h00;
            m_flag = 1'b0;
            m_ien  = 1'b0;
        end else begin
            bit any_on;
            bit all_ok;
            any_on = 0;
            all_ok = 1;
            for (int i = 0; i < 6; i++) begin
                if (m_alm[i][7]) begin
                    any_on = 1;
                    if (t_now[i] != {1'b0, m_alm[i][6:0]}) all_ok = 0;
                end
            end
            if (reg_wr && reg_addr < 3'd6) m_alm[reg_addr] = reg_wdata;
            if (reg_wr && reg_addr == 3'd6) begin
                m_ien = reg_wdata[3];
                if (!reg_wdata[0]) m_flag = 1'b0;
            end
            if (sec_tick && any_on && all_ok) m_flag = 1'b1;
        end
    end

    function automatic logic [7:0] model_read(input logic [2:0] a);
        if (a < 3'd6) return m_alm[a];
        if (a == 3'd6) return {4'b0, m_ien, 2'b00, m_flag};
        return 8'h00;
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, 3 ns after each rising edge.
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            check({7'b0, alarm_irq}, {7'b0, m_flag && m_ien}, "R10 irq");
            check(reg_rdata, model_read(reg_addr), (reg_addr == 3'd6) ? "R3 ctrl read" : "R2 read");
        end
    end

    task automatic cyc(input logic wr, input logic [2:0] a, input logic [7:0] d, input logic tk);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; sec_tick = tk;
    endtask

    task automatic peek(input logic [2:0] a, input logic [7:0] exp, input string tag);
        cyc(1'b0, a, 8'h00, 1'b0);
        @(posedge clk);
        #3;
        check(reg_rdata, exp, tag);
    endtask

    task automatic irq_is(input logic exp, input string tag);
        check({7'b0, alarm_irq}, {7'b0, exp}, tag);
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                            input logic [7:0] w, input logic [7:0] md, input logic [7:0] mo);
        @(negedge clk);
        t_now[0] = s; t_now[1] = mi; t_now[2] = h;
        t_now[3] = w; t_now[4] = md; t_now[5] = mo;
    endtask

    task automatic set_alarms(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                              input logic [7:0] w, input logic [7:0] md, input logic [7:0] mo);
        cyc(1'b1, 3'd0, s, 1'b0);
        cyc(1'b1, 3'd1, mi, 1'b0);
        cyc(1'b1, 3'd2, h, 1'b0);
        cyc(1'b1, 3'd3, w, 1'b0);
        cyc(1'b1, 3'd4, md, 1'b0);
        cyc(1'b1, 3'd5, mo, 1'b0);
    endtask

    task automatic tick_once();
        cyc(1'b0, 3'd6, 8'h00, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) t_now[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int i = 0; i < 7; i++) peek(3'(i), 8'h00, "R1 reset read");
        irq_is(1'b0, "R1 irq after reset");

        // R2: full byte write and read back
        for (int i = 0; i < 6; i++) cyc(1'b1, 3'(i), 8'(8'h11 * (i + 1)), 1'b0);
        for (int i = 0; i < 6; i++) peek(3'(i), 8'(8'h11 * (i + 1)), "R2 readback");
        cyc(1'b1, 3'd5, 8'hFF, 1'b0);
        peek(3'd5, 8'hFF, "R2 all ones");
        set_alarms(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);

        // R3: control layout
        cyc(1'b1, 3'd6, 8'h08, 1'b0);
        peek(3'd6, 8'h08, "R3 enable set");
        cyc(1'b1, 3'd6, 8'hF6, 1'b0);
        peek(3'd6, 8'h00, "R3 other bits read 0");
        cyc(1'b1, 3'd6, 8'h08, 1'b0);

        // R7 then R4: single-field match on seconds
        set_time(8'h30, 8'h15, 8'h08, 8'h03, 8'h21, 8'h06);
        set_alarms(8'hB0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        repeat (3) cyc(1'b0, 3'd6, 8'h00, 1'b0);
        peek(3'd6, 8'h08, "R7 match without tick");
        tick_once();
        peek(3'd6, 8'h09, "R4 single field hit");
        irq_is(1'b1, "R10 irq with flag and enable");

        // R8: sticky behaviour
        set_time(8'h31, 8'h15, 8'h08, 8'h03, 8'h21, 8'h06);
        tick_once();
        peek(3'd6, 8'h09, "R8 holds on mismatch tick");
        cyc(1'b1, 3'd6, 8'h09, 1'b0);
        peek(3'd6, 8'h09, "R8 write of 1 keeps flag");
        cyc(1'b1, 3'd6, 8'h01, 1'b0);
        peek(3'd6, 8'h01, "R10 enable off keeps flag");
        irq_is(1'b0, "R10 irq masked");
        cyc(1'b1, 3'd6, 8'h08, 1'b0);
        peek(3'd6, 8'h08, "R8 clear by writing 0");
        irq_is(1'b0, "R10 irq after clear");

        // R5: disabled field with conflicting value
        set_alarms(8'h17, 8'hC5, 8'h00, 8'h00, 8'h00, 8'h92);
        set_time(8'h59, 8'h45, 8'h08, 8'h03, 8'h21, 8'h12);
        tick_once();
        peek(3'd6, 8'h09, "R5 disabled field ignored");
        cyc(1'b1, 3'd6, 8'h08, 1'b0);

        // R11: one enabled field differs
        set_time(8'h59, 8'h45, 8'h08, 8'h03, 8'h21, 8'h11);
        tick_once();
        peek(3'd6, 8'h08, "R11 month mismatch");
        set_time(8'h59, 8'h44, 8'h08, 8'h03, 8'h21, 8'h12);
        tick_once();
        peek(3'd6, 8'h08, "R11 minute mismatch");

        // R6: nothing enabled
        set_alarms(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        tick_once();
        peek(3'd6, 8'h08, "R6 all zero no set");
        set_alarms(8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F);
        set_time(8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F, 8'h7F);
        tick_once();
        peek(3'd6, 8'h08, "R6 values without enable");

        // R4: all six enabled at upper limits
        set_alarms(8'hD9, 8'hD9, 8'hA3, 8'h86, 8'hB1, 8'h92);
        set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12);
        tick_once();
        peek(3'd6, 8'h09, "R4 all fields hit");

        // R9: clear and hit on the same edge
        cyc(1'b1, 3'd6, 8'h08, 1'b1);
        peek(3'd6, 8'h09, "R9 hit beats clear");
        set_time(8'h58, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12);
        cyc(1'b1, 3'd6, 8'h08, 1'b1);
        peek(3'd6, 8'h08, "R8 clear with non-hit tick");
        irq_is(1'b0, "R10 irq low after clear");

        repeat (2) cyc(1'b0, 3'd0, 8'h00, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule